// File: doc/BRIEF.md
# Shared RAM Slot Ownership Mapper

This block sits between the masters of a subsystem (two processor cores and a signal processor) and a small shared work RAM made of eight 32 KB slots. Two banks of eight byte-wide configuration registers hold the slot settings. One bank serves an instruction window and the other a data window. Each register names an owning master, a physical slot the logical slot is redirected to, and an enable. A master presents a request on a valid/ready stream: the window, a logical slot and an address within the slot. The block looks up the matching register. It then either passes the request on to the memory side with a remapped physical address, or refuses it and answers with a miss pulse and zero read data.

Software programs the registers through a plain byte-wide register port. The port writes in one cycle and reads back combinationally. Back-pressure rules are as follows. A granted request moves to the memory stream, and req_ready follows mem_ready, so a stalled memory stalls the master. A refused request is never forwarded and is accepted at once, whatever mem_ready is. The request fields must stay stable while req_valid is high and req_ready is low.

Top module: `shwram_slot_mapper`

## Requirements
- R1: After reset every configuration register reads 0, so every slot is disabled and every request misses.
- R2: Register byte address bits [2:0] pick the logical slot and bit [3] picks the bank (0 instruction, 1 data). A write stores bits [7], [4:2] and [1:0] of the byte. Bits [6:5] always read back as 0, and writes to them are ignored.
- R3: Register bits [1:0] hold the owner: 0 is the first core, 1 is the second core, and 2 or 3 both mean the signal processor. A request is granted only when the requester code (same encoding) names the same master as the owner.
- R4: Register bit 7 is the enable. With it at 0, no request to that slot is granted, whatever the owner.
- R5: A granted request drives mem_addr = {register bits [4:2], req_addr[14:0]}. It also passes req_we and req_wdata through unchanged.
- R6: A refused request is not forwarded (mem_valid stays 0) and is accepted at once. On the next cycle rsp_miss is 1 for exactly one cycle and rsp_rdata is 0. In every other cycle rsp_miss is 0 and rsp_rdata equals mem_rdata.
- R7: For a granted request, mem_valid equals req_valid and req_ready equals mem_ready.
- R8: A register write takes effect from the cycle after the write. A request presented in the same cycle as the write still sees the old setting.
- R9: The two banks are independent. A request in the instruction window uses only the instruction bank, and a request in the data window uses only the data bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address: bank in bit 3, slot in bits 2:0 |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| req_valid | input | 1 | Master request valid |
| req_ready | output | 1 | Master request accepted |
| req_window | input | 1 | 0 instruction window, 1 data window |
| req_master | input | 2 | Requester code: 0 core A, 1 core B, 2/3 signal processor |
| req_slot | input | 3 | Logical slot index |
| req_addr | input | SLOT_AW | Byte address within the slot |
| req_we | input | 1 | Write request |
| req_wdata | input | DATA_W | Write data |
| mem_valid | output | 1 | Forwarded request valid |
| mem_ready | input | 1 | Memory side ready |
| mem_addr | output | 3+SLOT_AW | Physical RAM address |
| mem_we | output | 1 | Forwarded write enable |
| mem_wdata | output | DATA_W | Forwarded write data |
| mem_rdata | input | DATA_W | Read data from memory |
| rsp_miss | output | 1 | One-cycle pulse after a refused request |
| rsp_rdata | output | DATA_W | Read data to the master, zero on a miss |

## Verification
The assertions assume that a master holds its request fields stable while it is stalled. They also assume that mem_ready is a level from the memory side that is driven independently of mem_valid. The stimulus presents each request for a single cycle with mem_ready high during the sweeps, and lowers mem_ready only in a directed back-pressure test. The bench walks every byte value through every register. After each value it issues a request from every master code to both windows, so owner classes, enables, offsets and bank independence are all covered against a model computed in the bench.

// File: rtl/shwram_pkg.sv
package shwram_pkg;
  localparam int NUM_SLOTS  = 8;
  localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);
  localparam int NUM_BANKS  = 2;
  localparam int CFG_W      = 8;

  typedef enum logic [1:0] {
    MC_CORE_A = 2'd0,
    MC_CORE_B = 2'd1,
    MC_SIGPROC = 2'd2
  } master_class_e;

  typedef struct packed {
    logic                  en;
    logic [1:0]            rsv;
    logic [SLOT_IDX_W-1:0] phys;
    logic [1:0]            owner;
  } slot_cfg_t;

  localparam logic [CFG_W-1:0] CFG_WMASK = 8'b1001_1111;

  function automatic master_class_e class_of(input logic [1:0] code);
    if (code[1]) return MC_SIGPROC;
    else if (code[0]) return MC_CORE_B;
    else return MC_CORE_A;
  endfunction
endpackage

// File: rtl/shwram_cfg_bank.sv
module shwram_cfg_bank
  import shwram_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SLOT_IDX_W-1:0] wr_idx,
  input  logic [CFG_W-1:0]      wr_data,
  input  logic [SLOT_IDX_W-1:0] rd_idx,
  output logic [CFG_W-1:0]      rd_data,
  input  logic [SLOT_IDX_W-1:0] lk_idx,
  output slot_cfg_t             lk_cfg
);
  slot_cfg_t cfg_q [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[i] <= '0;
      else if (wr_en && wr_idx == i[SLOT_IDX_W-1:0])
        cfg_q[i] <= slot_cfg_t'(wr_data & CFG_WMASK);
    end

    // R2: reserved field never becomes nonzero
    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[i].rsv == 2'b00);
  end

  assign rd_data = cfg_q[rd_idx];
  assign lk_cfg  = cfg_q[lk_idx];
endmodule

// File: rtl/shwram_grant.sv
module shwram_grant
  import shwram_pkg::*;
#(
  parameter int SLOT_AW = 15
) (
  input  slot_cfg_t                      cfg,
  input  logic [1:0]                     master,
  input  logic [SLOT_AW-1:0]             offs,
  output logic                           hit,
  output logic [SLOT_IDX_W+SLOT_AW-1:0]  phys_addr
);
  master_class_e owner_c, req_c;
  always_comb begin
    owner_c   = class_of(cfg.owner);
    req_c     = class_of(master);
    hit       = cfg.en && (owner_c == req_c);
    phys_addr = {cfg.phys, offs};
  end
endmodule

// File: rtl/shwram_miss_tracker.sv
module shwram_miss_tracker #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_miss,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_miss,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic miss_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miss_q <= 1'b0;
    else        miss_q <= take_miss;
  end
  assign rsp_miss  = miss_q;
  assign rsp_rdata = miss_q ? '0 : mem_rdata;

  // R6: every refused request yields a miss pulse on the next cycle
  p_miss_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_miss |=> rsp_miss);
  // R6: a miss pulse has a refused request behind it
  p_miss_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> $past(take_miss));
endmodule

// File: rtl/shwram_slot_mapper.sv
module shwram_slot_mapper
  import shwram_pkg::*;
#(
  parameter int SLOT_AW = 15,
  parameter int DATA_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [SLOT_IDX_W:0]           reg_addr,
  input  logic [CFG_W-1:0]              reg_wdata,
  output logic [CFG_W-1:0]              reg_rdata,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_window,
  input  logic [1:0]                    req_master,
  input  logic [SLOT_IDX_W-1:0]         req_slot,
  input  logic [SLOT_AW-1:0]            req_addr,
  input  logic                          req_we,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          mem_valid,
  input  logic                          mem_ready,
  output logic [SLOT_IDX_W+SLOT_AW-1:0] mem_addr,
  output logic                          mem_we,
  output logic [DATA_W-1:0]             mem_wdata,
  input  logic [DATA_W-1:0]             mem_rdata,
  output logic                          rsp_miss,
  output logic [DATA_W-1:0]             rsp_rdata
);
  localparam int PHYS_AW = SLOT_IDX_W + SLOT_AW;

  logic [CFG_W-1:0] bank_rd  [NUM_BANKS];
  slot_cfg_t        bank_cfg [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    shwram_cfg_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_we && reg_addr[SLOT_IDX_W] == b[0]),
      .wr_idx  (reg_addr[SLOT_IDX_W-1:0]),
      .wr_data (reg_wdata),
      .rd_idx  (reg_addr[SLOT_IDX_W-1:0]),
      .rd_data (bank_rd[b]),
      .lk_idx  (req_slot),
      .lk_cfg  (bank_cfg[b])
    );
  end

  assign reg_rdata = bank_rd[reg_addr[SLOT_IDX_W]];

  slot_cfg_t          sel_cfg;
  logic               hit;
  logic [PHYS_AW-1:0] phys_addr;
  assign sel_cfg = bank_cfg[req_window];

  shwram_grant #(.SLOT_AW(SLOT_AW)) u_grant (
    .cfg       (sel_cfg),
    .master    (req_master),
    .offs      (req_addr),
    .hit       (hit),
    .phys_addr (phys_addr)
  );

  assign mem_valid = req_valid && hit;
  assign mem_addr  = phys_addr;
  assign mem_we    = req_we;
  assign mem_wdata = req_wdata;
  assign req_ready = hit ? mem_ready : 1'b1;

  shwram_miss_tracker #(.DATA_W(DATA_W)) u_miss (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_miss (req_valid && !hit),
    .mem_rdata (mem_rdata),
    .rsp_miss  (rsp_miss),
    .rsp_rdata (rsp_rdata)
  );

  // R4: nothing is forwarded to a disabled slot
  p_fwd_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> sel_cfg.en);
  // R3: forwarded requests come from the owner's class
  p_fwd_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (req_master[1] ? sel_cfg.owner[1]
                                 : (!sel_cfg.owner[1] && sel_cfg.owner[0] == req_master[0])));
  // R5: the in-slot offset is preserved
  p_offs_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[SLOT_AW-1:0] == req_addr);
  // R7: a stalled memory stalls the master
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |-> !req_ready);
  // R6: a miss pulse returns zero data
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> rsp_rdata == '0);
  // R8: a register written last cycle is visible to a request on it now
  p_wr_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == {req_window, req_slot} && reg_wdata[7] == 1'b0)
      |=> (($past(reg_addr) == {req_window, req_slot}) |-> !mem_valid));
endmodule

// File: tb/tb_shwram_slot_mapper.sv
module tb_shwram_slot_mapper;
  localparam int SLOT_AW = 15;
  localparam int DATA_W  = 32;
  localparam logic [DATA_W-1:0] MEMD = 32'hA5C3_0F1E;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [3:0] reg_addr = 0; logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic req_valid = 0, req_ready, req_window = 0, req_we = 0;
  logic [1:0] req_master = 0; logic [2:0] req_slot = 0;
  logic [SLOT_AW-1:0] req_addr = 0; logic [DATA_W-1:0] req_wdata = 0;
  logic mem_valid, mem_ready = 1, mem_we;
  logic [SLOT_AW+2:0] mem_addr; logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata = MEMD;
  logic rsp_miss; logic [DATA_W-1:0] rsp_rdata;

  int checks = 0, fails = 0;
  logic [7:0] mdl [16];
  bit done = 0;

  always #10 clk = ~clk;

  shwram_slot_mapper #(.SLOT_AW(SLOT_AW), .DATA_W(DATA_W)) dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int cls(input logic [1:0] c);
    return c[1] ? 2 : int'(c[0]);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 0;
    mdl[a] = d & 8'h9F;
  endtask

  task automatic rd_chk(input logic [3:0] a, input string tag);
    @(negedge clk);
    reg_addr = a; #2;
    chk(tag, reg_rdata, mdl[a]);
  endtask

  // one-cycle request with mem_ready high; checks forward path and response
  task automatic do_req(input logic w, input logic [2:0] s, input logic [1:0] m,
                        input logic [SLOT_AW-1:0] a, input string tag);
    logic [7:0] c;
    bit hit;
    c = mdl[{w, s}];
    hit = c[7] && cls(c[1:0]) == cls(m);
    @(negedge clk);
    req_valid = 1; req_window = w; req_slot = s; req_master = m; req_addr = a;
    req_we = a[0]; req_wdata = {a, 17'h1ABCD};
    #2;
    chk({tag, " R3/R4 grant"}, mem_valid, hit);
    chk({tag, " R7 ready"}, req_ready, 1'b1);
    if (hit) begin
      chk({tag, " R5 addr"}, mem_addr, {c[4:2], a});
      chk({tag, " R5 data"}, {mem_we, mem_wdata}, {a[0], a, 17'h1ABCD});
    end
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    chk({tag, " R6 miss flag"}, rsp_miss, !hit);
    chk({tag, " R6 rdata"}, rsp_rdata, hit ? MEMD : '0);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    for (int i = 0; i < 16; i++) rd_chk(i[3:0], "R1 reset reg");
    for (int m = 0; m < 4; m++) do_req(m[0], 3'(m), m[1:0], 15'h1234, "R1 reset req");

    // R2/R3/R4/R5/R9 sweep: every byte in every register
    for (int r = 0; r < 16; r++) begin
      for (int v = 0; v < 256; v++) begin
        wr(r[3:0], v[7:0]);
        if (v % 37 == 0) rd_chk(r[3:0], "R2 readback");
        for (int m = 0; m < 4; m++) begin
          do_req(r[3], r[2:0], m[1:0], 15'(v * 129 + m), "R3 sweep");
          if (v % 16 == 0) do_req(!r[3], r[2:0], m[1:0], 15'(v), "R9 other bank");
        end
      end
      rd_chk(r[3:0], "R2 final readback");
      wr(r[3:0], 8'h00);
    end

    // R8: write in same cycle as request sees old value, next cycle new
    wr(4'h5, 8'h80 | (3'd6 << 2));
    @(negedge clk);
    reg_we = 1; reg_addr = 4'h5; reg_wdata = 8'h00;
    req_valid = 1; req_window = 0; req_slot = 3'd5; req_master = 2'd0; req_addr = 15'h7FFF;
    #2 chk("R8 old value same cycle", mem_valid, 1'b1);
    @(posedge clk); #1 reg_we = 0; mdl[5] = 8'h00;
    @(negedge clk);
    chk("R8 new value next cycle", mem_valid, 1'b0);
    @(posedge clk); #1 req_valid = 0;

    // R7: back-pressure on granted, no effect on refused
    wr(4'hA, 8'h80 | 8'h03);
    @(negedge clk);
    mem_ready = 0; req_valid = 1; req_window = 1; req_slot = 3'd2;
    req_master = 2'd2; req_addr = 15'h0042;
    #2 chk("R7 stall valid", mem_valid, 1'b1);
    chk("R7 stall ready", req_ready, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R7 no miss while stalled", rsp_miss, 1'b0);
    req_master = 2'd1; #2;
    chk("R7 refused accepted", req_ready, 1'b1);
    chk("R6 refused not forwarded", mem_valid, 1'b0);
    @(posedge clk); #1 req_valid = 0; mem_ready = 1;
    @(negedge clk);
    chk("R6 miss after refusal", rsp_miss, 1'b1);
    @(negedge clk);
    chk("R6 miss one cycle", rsp_miss, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule